// File: doc/BRIEF.md
# Compare-Value Timer with Count Offset

This block is a per-core event timer. It watches a shared 64-bit free-running count that a source outside the block supplies. It subtracts a programmable 64-bit offset from that count to form its own timer count. The timer fires once the timer count reaches a 64-bit compare value. When the offset is zero, an instance acts as a physical timer. When the offset is loaded, the same design acts as a virtual timer whose count is shifted. A core normally holds two instances side by side, and their level-sensitive interrupt lines go to an interrupt controller outside the block.

Software sets the firing point in one of two ways:

- It writes an absolute 64-bit compare value.
- It writes a signed 32-bit distance from the current timer count. Reading that relative view returns the remaining distance.

A small control register holds the enable bit and the mask bit, and shows a read-only fire status. Access goes through a single-cycle register port: a select code, a write strobe, write data, and combinational read data.

The fire condition is evaluated at every clock edge by a four-state machine:

- OFF: the timer is disabled.
- WAIT: the timer is enabled and the count is below the compare value.
- FIRE: the timer has fired and is unmasked.
- HELD: the timer has fired and is masked.

The next state comes from the register values after that edge's write and from the count at that edge. Every transition is therefore possible from every state. A write that changes the condition moves the state at the same edge as the write itself.

The transitions are:

- OFF to WAIT, FIRE or HELD: arm.
- Any state to OFF: disarm.
- WAIT to FIRE: expire.
- WAIT to HELD: expire masked.
- FIRE to HELD: mask.
- HELD to FIRE: unmask.
- FIRE or HELD to WAIT: rearm, after the compare value moves ahead.

Top module: `cmp_timer`

## Requirements
- R1: After reset, the compare value, the offset and the control register are zero, the state is OFF and `irq_out` is 0.
- R2: A write with select code 0 stores all 64 bits of `wr_data` as the compare value. A read with select code 0 returns that value.
- R3: A write with select code 3 stores the 64-bit offset. A read with select code 3 returns it. The timer count is `sys_count` minus the offset, modulo 2^64.
- R4: A read with select code 1 returns, in bits 31:0, the low 32 bits of the compare value minus the current timer count. Bits 63:32 read as zero.
- R5: A write with select code 1 sets the compare value to the timer count at that edge plus `wr_data[31:0]` sign-extended to 64 bits.
- R6: A write with select code 2 sets enable from `wr_data[0]` and mask from `wr_data[1]`. A read with select code 2 returns enable in bit 0, mask in bit 1 and status in bit 2, with the upper bits zero. The written bit 2 is ignored.
- R7: At every clock edge, status becomes 1 exactly when enable is 1 and the timer count is greater than or equal to the compare value, compared unsigned. Both are taken from the register values after that edge and the `sys_count` present at that edge.
- R8: `irq_out` is 1 exactly when enable is 1, status is 1 and mask is 0. It drops at the first edge at which any of these stops holding.
- R9: A write to the compare value, the relative view, the control register or the offset takes effect on status and `irq_out` at the same edge as the write.
- R10: Select codes 4 to 7 read as zero, and a write with them changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_count | input | 64 | Shared free-running count |
| wr_en | input | 1 | Register write strobe |
| sel | input | 3 | Register select code (0 compare, 1 relative, 2 control, 3 offset) |
| wr_data | input | 64 | Register write data |
| rd_data | output | 64 | Combinational read data for `sel` |
| irq_out | output | 1 | Level-sensitive timer interrupt |

## Verification
On every cycle, the assertions check the following:

- An asserted interrupt always comes with enable set and mask clear.
- An asserted interrupt or status matches an unsigned comparison of the previous edge's count, minus the offset, against the compare value.
- Offset and compare writes land in the registers.
- Unused select codes leave the registers untouched and read as zero.

Only the bench's scenarios show the rest:

- The relative view's sign-extended arithmetic.
- That a write to the status bit is ignored.
- The exact edge at which a write or a count crossing moves the interrupt.
- Wrap-around when the offset exceeds the shared count.

The bench compares each of these against its own register model.

// File: rtl/cmp_timer_pkg.sv
`timescale 1ns/1ps
package cmp_timer_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_FIRE = 2'd2,
        ST_HELD = 2'd3
    } tmr_state_e;

    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_ABS = 3'd0;
    localparam logic [SEL_W-1:0] SEL_REL = 3'd1;
    localparam logic [SEL_W-1:0] SEL_CTL = 3'd2;
    localparam logic [SEL_W-1:0] SEL_OFS = 3'd3;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_MASK_BIT = 1;
    localparam int CTL_STAT_BIT = 2;
    localparam int CTL_W        = 3;

endpackage

// File: rtl/cmp_timer_regs.sv
`timescale 1ns/1ps
module cmp_timer_regs
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int REL_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] count_now,
    output logic [CNT_W-1:0] cmp_q,
    output logic [CNT_W-1:0] off_q,
    output logic             en_q,
    output logic             mask_q,
    output logic [CNT_W-1:0] cmp_d,
    output logic [CNT_W-1:0] off_d,
    output logic             en_d,
    output logic             mask_d
);

    localparam int EXT_W = CNT_W - REL_W;

    logic [CNT_W-1:0] rel_ext;

    // sign-extend the relative distance to full count width
    assign rel_ext = {{EXT_W{wr_data[REL_W-1]}}, wr_data[REL_W-1:0]};

    always_comb begin
        cmp_d  = cmp_q;
        off_d  = off_q;
        en_d   = en_q;
        mask_d = mask_q;
        if (wr_en) begin
            case (sel)
                SEL_ABS: cmp_d = wr_data;
                SEL_REL: cmp_d = count_now + rel_ext;
                SEL_CTL: begin
                    en_d   = wr_data[CTL_EN_BIT];
                    mask_d = wr_data[CTL_MASK_BIT];
                end
                SEL_OFS: off_d = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            off_q  <= '0;
            en_q   <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            cmp_q  <= cmp_d;
            off_q  <= off_d;
            en_q   <= en_d;
            mask_q <= mask_d;
        end
    end

endmodule

// File: rtl/cmp_timer_cmp.sv
`timescale 1ns/1ps
module cmp_timer_cmp #(
    parameter int CNT_W = 64,
    parameter int REL_W = 32
) (
    input  logic [CNT_W-1:0] sys_count,
    input  logic [CNT_W-1:0] off_q,
    input  logic [CNT_W-1:0] cmp_q,
    input  logic [CNT_W-1:0] off_d,
    input  logic [CNT_W-1:0] cmp_d,
    output logic [CNT_W-1:0] count_now,
    output logic [REL_W-1:0] rel_now,
    output logic             ge_next
);

    logic [CNT_W-1:0] count_next;
    logic [CNT_W-1:0] dist_now;

    // timer count seen with the registers as they stand
    assign count_now  = sys_count - off_q;
    assign dist_now   = cmp_q - count_now;
    assign rel_now    = dist_now[REL_W-1:0];

    // timer count seen with the registers as they will be after this edge
    assign count_next = sys_count - off_d;
    assign ge_next    = (count_next >= cmp_d);

endmodule

// File: rtl/cmp_timer_fsm.sv
`timescale 1ns/1ps
module cmp_timer_fsm
    import cmp_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_d,
    input  logic       mask_d,
    input  logic       ge_d,
    output tmr_state_e state_q,
    output logic       irq,
    output logic       status
);

    tmr_state_e state_n;

    // transition selection, named per state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_d)                 state_n = !ge_d ? ST_WAIT : (mask_d ? ST_HELD : ST_FIRE); // arm
            end
            ST_WAIT: begin
                if (!en_d)                state_n = ST_OFF;    // disarm
                else if (ge_d)            state_n = mask_d ? ST_HELD : ST_FIRE; // expire
            end
            ST_FIRE: begin
                if (!en_d)                state_n = ST_OFF;    // disarm
                else if (!ge_d)           state_n = ST_WAIT;   // rearm
                else if (mask_d)          state_n = ST_HELD;   // mask
            end
            ST_HELD: begin
                if (!en_d)                state_n = ST_OFF;    // disarm
                else if (!ge_d)           state_n = ST_WAIT;   // rearm
                else if (!mask_d)         state_n = ST_FIRE;   // unmask
            end
            default:                      state_n = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_n;
    end

    // Moore outputs
    always_comb begin
        irq    = 1'b0;
        status = 1'b0;
        unique case (state_q)
            ST_OFF:  ;
            ST_WAIT: ;
            ST_FIRE: begin irq = 1'b1; status = 1'b1; end
            ST_HELD: status = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/cmp_timer.sv
`timescale 1ns/1ps
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int REL_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] sys_count,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq_out
);

    logic [CNT_W-1:0] cmp_q, off_q, cmp_d, off_d;
    logic             en_q, mask_q, en_d, mask_d;
    logic [CNT_W-1:0] count_now;
    logic [REL_W-1:0] rel_now;
    logic             ge_next;
    logic             status;
    tmr_state_e       state_q;

    cmp_timer_regs #(.CNT_W(CNT_W), .REL_W(REL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .sel       (sel),
        .wr_data   (wr_data),
        .count_now (count_now),
        .cmp_q     (cmp_q),
        .off_q     (off_q),
        .en_q      (en_q),
        .mask_q    (mask_q),
        .cmp_d     (cmp_d),
        .off_d     (off_d),
        .en_d      (en_d),
        .mask_d    (mask_d)
    );

    cmp_timer_cmp #(.CNT_W(CNT_W), .REL_W(REL_W)) u_cmp (
        .sys_count (sys_count),
        .off_q     (off_q),
        .cmp_q     (cmp_q),
        .off_d     (off_d),
        .cmp_d     (cmp_d),
        .count_now (count_now),
        .rel_now   (rel_now),
        .ge_next   (ge_next)
    );

    cmp_timer_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_d    (en_d),
        .mask_d  (mask_d),
        .ge_d    (ge_next),
        .state_q (state_q),
        .irq     (irq_out),
        .status  (status)
    );

    // read multiplexer
    always_comb begin
        rd_data = '0;
        case (sel)
            SEL_ABS: rd_data = cmp_q;
            SEL_REL: rd_data = {{(CNT_W-REL_W){1'b0}}, rel_now};
            SEL_CTL: begin
                rd_data[CTL_EN_BIT]   = en_q;
                rd_data[CTL_MASK_BIT] = mask_q;
                rd_data[CTL_STAT_BIT] = status;
            end
            SEL_OFS: rd_data = off_q;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/cmp_timer_chk.sv
`timescale 1ns/1ps
module cmp_timer_chk #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] sys_count,
    input logic             wr_en,
    input logic [2:0]       sel,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] rd_data,
    input logic             irq_out,
    input logic [CNT_W-1:0] cmp_q,
    input logic [CNT_W-1:0] off_q,
    input logic             en_q,
    input logic             mask_q,
    input logic             status
);

    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (en_q && !mask_q && status));

    assert_status_cond_R7: assert property (@(posedge clk) disable iff (!rst_n)
        status |-> (en_q && (($past(sys_count) - off_q) >= cmp_q)));

    assert_offset_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 3'd3) |=> (off_q == $past(wr_data)));

    assert_compare_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 3'd0) |=> (cmp_q == $past(wr_data)));

    assert_unused_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel[2]) |=> ($stable(cmp_q) && $stable(off_q) && $stable(en_q) && $stable(mask_q)));

    assert_unused_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sel[2] |-> (rd_data == '0));

endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_count (sys_count),
    .wr_en     (wr_en),
    .sel       (sel),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .irq_out   (irq_out),
    .cmp_q     (cmp_q),
    .off_q     (off_q),
    .en_q      (en_q),
    .mask_q    (mask_q),
    .status    (status)
);

// File: tb/cmp_timer_test.sv
`timescale 1ns/1ps
module cmp_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_count = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  sel = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [63:0] m_cmp = '0, m_off = '0;
    logic        m_en = 0, m_mask = 0, m_stat = 0, m_irq = 0;

    cmp_timer uut (
        .clk(clk), .rst_n(rst_n), .sys_count(sys_count), .wr_en(wr_en),
        .sel(sel), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_read(input logic [2:0] s);
        logic [63:0] d;
        case (s)
            3'd0: return m_cmp;
            3'd1: begin d = m_cmp - (sys_count - m_off); return {32'b0, d[31:0]}; end
            3'd2: return {61'b0, m_stat, m_mask, m_en};
            3'd3: return m_off;
            default: return '0;
        endcase
    endfunction

    task automatic model_edge(input logic we, input logic [2:0] s, input logic [63:0] d, input logic [63:0] sc);
        logic [63:0] cnt;
        cnt = sc - m_off;
        if (we) begin
            case (s)
                3'd0: m_cmp = d;
                3'd1: m_cmp = cnt + {{32{d[31]}}, d[31:0]};
                3'd2: begin m_en = d[0]; m_mask = d[1]; end
                3'd3: m_off = d;
                default: ;
            endcase
        end
        m_stat = m_en && ((sc - m_off) >= m_cmp);
        m_irq  = m_stat && !m_mask;
    endtask

    // called at a negative edge; returns at the next negative edge
    task automatic step(input logic we, input logic [2:0] s, input logic [63:0] d, input logic [63:0] sc);
        wr_en = we; sel = s; wr_data = d; sys_count = sc;
        @(posedge clk);
        model_edge(we, s, d, sc);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] s);
        sel = s;
        #1;
        chk(tag, rd_data, exp_read(s));
    endtask

    task automatic irq_chk(input string tag);
        chk(tag, {63'b0, irq_out}, {63'b0, m_irq});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] sc;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq after reset", {63'b0, irq_out}, 64'd0);
        rd_chk("R1 compare after reset", 3'd0);
        rd_chk("R1 control after reset", 3'd2);
        rd_chk("R1 offset after reset", 3'd3);

        sc = 64'd1000;
        step(1, 3'd0, 64'd1010, sc);                 rd_chk("R2 compare readback", 3'd0);
        sc++; step(1, 3'd2, 64'd1, sc);              irq_chk("R7 enabled below compare");
        rd_chk("R6 control enable only", 3'd2);
        while (sc < 64'd1009) begin sc++; step(0, 3'd0, 0, sc); end
        irq_chk("R7 one below compare");
        sc++; step(0, 3'd0, 0, sc);
        chk("R8 fires at compare", {63'b0, irq_out}, 64'd1);
        sc++; step(1, 3'd2, 64'd3, sc);
        chk("R9 mask drops irq same edge", {63'b0, irq_out}, 64'd0);
        rd_chk("R6 status with mask", 3'd2);
        sc++; step(1, 3'd2, 64'd4, sc);
        rd_chk("R6 status write ignored", 3'd2);
        irq_chk("R8 disabled no irq");
        sc++; step(1, 3'd3, 64'd500, sc);            rd_chk("R3 offset readback", 3'd3);
        rd_chk("R4 relative read", 3'd1);
        sc++; step(1, 3'd2, 64'd1, sc);              irq_chk("R3 offset pushes count back");
        sc++; step(1, 3'd1, 64'h0000_0000_FFFF_FFFB, sc);
        rd_chk("R5 negative relative write", 3'd0);
        chk("R9 relative write fires same edge", {63'b0, irq_out}, 64'd1);
        sc++; step(1, 3'd1, 64'd20, sc);
        chk("R5 positive relative write clears", {63'b0, irq_out}, 64'd0);
        rd_chk("R4 relative after write", 3'd1);
        sc++; step(1, 3'd5, 64'hDEAD_BEEF_0000_0001, sc);
        rd_chk("R10 compare unchanged", 3'd0);
        rd_chk("R10 unused select reads zero", 3'd5);
        // wrap: offset above shared count
        sc++; step(1, 3'd3, sc + 64'd10, sc);
        sc++; step(1, 3'd0, 64'hFFFF_FFFF_FFFF_FFF0, sc);
        irq_chk("R7 wrapped count is large unsigned");
        rd_chk("R4 relative with wrap", 3'd1);

        // random phase
        for (int i = 0; i < 600; i++) begin
            logic [2:0]  s;
            logic [63:0] d;
            logic        we;
            s  = 3'($urandom_range(0, 5));
            we = ($urandom_range(0, 2) != 0);
            d  = {$urandom(), $urandom()};
            if (s == 3'd0 || s == 3'd3) d = sc + 64'($urandom_range(0, 40)) - 64'd20;
            if (s == 3'd3) d = 64'($urandom_range(0, 30));
            if (s == 3'd1) d = 64'($signed(32'($urandom_range(0, 40)) - 32'd20));
            sc = sc + 64'($urandom_range(0, 3));
            step(we, s, d, sc);
            irq_chk("R8 random irq");
            rd_chk("R7 random read", 3'($urandom_range(0, 7)));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule